// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit (parameter `W`) integer multiplication and division one bit per clock. A start command carries a two-bit operation code and two operands. The unit then runs a shift-add loop for multiplies or a restoring-subtract loop for divides. It writes the result into two dedicated registers, HI and LO, and it does not return the result to a general destination.

A multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. Separate move commands copy HI or LO out through a registered read port, or overwrite one of them with a supplied word. A read issued while a computation is running is held and served once the new result is in place. No operation raises an overflow indication, and division by zero finishes normally with fixed values.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 (signed multiply) leaves the two's-complement 2W-bit product of the operands with its upper W bits in HI and its lower W bits in LO.
- R2: Operation code 2'b01 (unsigned multiply) leaves the unsigned 2W-bit product in HI (upper) and LO (lower).
- R3: Operation code 2'b11 (unsigned divide) of a nonzero divisor leaves the quotient in LO and the remainder in HI.
- R4: Operation code 2'b10 (signed divide) of a nonzero divisor truncates the quotient toward zero into LO. The remainder in HI takes the sign of the dividend. The most negative dividend divided by -1 yields LO = most negative value and HI = 0, with no error.
- R5: Division by a zero divisor completes normally with HI equal to the dividend. For unsigned divide LO is all ones. For signed divide LO is 1 when the dividend is negative and all ones (-1) otherwise.
- R6: `busy_o` rises in the cycle after a start is accepted and stays high for exactly W+1 cycles. HI and LO hold the new result from the first cycle with `busy_o` low.
- R7: A start raised while `busy_o` is high is ignored, and the running operation finishes with its own operands.
- R8: A move-from request (`mfhi_i` or `mflo_i`) made while idle gives a one-cycle `rd_valid_o` pulse in the next cycle, with `rd_data_o` holding a copy of the register. When both are raised together, HI is returned.
- R9: A move-from request made while `busy_o` is high is held. `rd_valid_o` stays low until `busy_o` falls, and the request is served in the cycle after that with the newly written result.
- R10: A move-to command (`mthi_i` or `mtlo_i`) overwrites only the selected register with `wr_data_i`, and the other register keeps its value.
- R11: After reset, HI and LO read as zero, and `busy_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when not busy |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | W | Multiplicand or dividend |
| opb_i | input | W | Multiplier or divisor |
| busy_o | output | 1 | Computation in progress |
| mfhi_i | input | 1 | Move-from-HI request |
| mflo_i | input | 1 | Move-from-LO request |
| mthi_i | input | 1 | Move-to-HI command |
| mtlo_i | input | 1 | Move-to-LO command |
| wr_data_i | input | W | Value for move-to commands |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | W | Copy of HI or LO |

## Verification
Damaged iteration state, such as a wrong step count, a lost carry or borrow, or a missed sign correction, stays hidden until the first move-from after `busy_o` falls. The bench therefore reads HI and LO after every operation and times the busy window to the cycle. A wrong pending-read state shows as an early or missing `rd_valid_o` within two cycles of `busy_o` falling. Corrupted HI or LO from a move-to shows on the very next read of the other register.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [1:0] {
      OP_MULS = 2'b00,
      OP_MULU = 2'b01,
      OP_DIVS = 2'b10,
      OP_DIVU = 2'b11
   } md_op_e;
endpackage

// File: rtl/md_iter_core.sv
module md_iter_core
   import muldiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] res_hi_o,
   output logic [W-1:0] res_lo_o
);
   localparam int CW = $clog2(W + 1);

   logic          busy_q, div_q, neg_main_q, neg_rem_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  m_q, low_q;
   logic [W:0]    acc_q;

   // operand preparation
   logic         op_signed, op_div, sgn_a, sgn_b;
   logic [W-1:0] mag_a, mag_b;
   always_comb begin
      op_signed = (md_op_e'(op_i) == OP_MULS) || (md_op_e'(op_i) == OP_DIVS);
      op_div    = op_i[1];
      sgn_a     = op_signed & a_i[W-1];
      sgn_b     = op_signed & b_i[W-1];
      mag_a     = sgn_a ? (~a_i + 1'b1) : a_i;
      mag_b     = sgn_b ? (~b_i + 1'b1) : b_i;
   end

   // one iteration step
   logic [W:0]   mul_sum, div_shift, div_trial;
   logic [W:0]   acc_nx;
   logic [W-1:0] low_nx;
   always_comb begin
      mul_sum   = {1'b0, acc_q[W-1:0]} + (low_q[0] ? {1'b0, m_q} : '0);
      div_shift = {acc_q[W-1:0], low_q[W-1]};
      div_trial = div_shift - {1'b0, m_q};
      if (div_q) begin
         if (!div_trial[W]) begin
            acc_nx = div_trial;
            low_nx = {low_q[W-2:0], 1'b1};
         end else begin
            acc_nx = div_shift;
            low_nx = {low_q[W-2:0], 1'b0};
         end
      end else begin
         acc_nx = {1'b0, mul_sum[W:1]};
         low_nx = {mul_sum[0], low_q[W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         div_q      <= 1'b0;
         neg_main_q <= 1'b0;
         neg_rem_q  <= 1'b0;
         cnt_q      <= '0;
         m_q        <= '0;
         low_q      <= '0;
         acc_q      <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q     <= 1'b1;
            div_q      <= op_div;
            neg_main_q <= sgn_a ^ sgn_b;
            neg_rem_q  <= sgn_a;
            cnt_q      <= CW'(W);
            m_q        <= op_div ? mag_b : mag_a;
            low_q      <= op_div ? mag_a : mag_b;
            acc_q      <= '0;
         end
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         acc_q <= acc_nx;
         low_q <= low_nx;
      end else begin
         busy_q <= 1'b0;
      end
   end

   // final sign correction
   logic [2*W-1:0] prod;
   logic [W-1:0]   quo, rem;
   always_comb begin
      prod = {acc_q[W-1:0], low_q};
      if (neg_main_q) prod = ~prod + 1'b1;
      quo = neg_main_q ? (~low_q + 1'b1) : low_q;
      rem = neg_rem_q ? (~acc_q[W-1:0] + 1'b1) : acc_q[W-1:0];
      res_hi_o = div_q ? rem : prod[2*W-1:W];
      res_lo_o = div_q ? quo : prod[W-1:0];
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);

   // R7
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done_o) |=> (busy_q && $stable(m_q) && $stable(div_q)));
endmodule

// File: rtl/md_hilo.sv
module md_hilo #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         busy_i,
   input  logic         done_i,
   input  logic [W-1:0] res_hi_i,
   input  logic [W-1:0] res_lo_i,
   input  logic         mthi_i,
   input  logic         mtlo_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         mfhi_i,
   input  logic         mflo_i,
   output logic         rd_valid_o,
   output logic [W-1:0] rd_data_o
);
   localparam int LO_IDX = 0;
   localparam int HI_IDX = 1;

   logic [W-1:0] hl_q [2];
   logic [W-1:0] res_v [2];
   logic [1:0]   mt_v;
   logic         pend_q, pend_sel_q;
   logic         req_any, req_sel, srv_sel;

   always_comb begin
      res_v[LO_IDX] = res_lo_i;
      res_v[HI_IDX] = res_hi_i;
      mt_v          = {mthi_i, mtlo_i};
      req_any       = mfhi_i | mflo_i;
      req_sel       = mfhi_i;
      srv_sel       = req_any ? req_sel : pend_sel_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) hl_q[i] <= '0;
      end else begin
         for (int i = 0; i < 2; i++) begin
            if (done_i)                 hl_q[i] <= res_v[i];
            else if (!busy_i && mt_v[i]) hl_q[i] <= wr_data_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_sel_q <= 1'b0;
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else if (busy_i) begin
         rd_valid_o <= 1'b0;
         if (req_any) begin
            pend_q     <= 1'b1;
            pend_sel_q <= req_sel;
         end
      end else if (req_any || pend_q) begin
         rd_valid_o <= 1'b1;
         rd_data_o  <= srv_sel ? hl_q[HI_IDX] : hl_q[LO_IDX];
         pend_q     <= 1'b0;
      end else begin
         rd_valid_o <= 1'b0;
      end
   end

   // R6
   result_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |-> (hl_q[HI_IDX] == $past(res_hi_i) && hl_q[LO_IDX] == $past(res_lo_i)));
   // R6
   hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !done_i) |=> ($stable(hl_q[HI_IDX]) && $stable(hl_q[LO_IDX])));
   // R9
   rd_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !$past(busy_i));
   // R8
   rd_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> ($past(mfhi_i) || $past(mflo_i) || $past(pend_q)));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] opa_i,
   input  logic [W-1:0] opb_i,
   output logic         busy_o,
   input  logic         mfhi_i,
   input  logic         mflo_i,
   input  logic         mthi_i,
   input  logic         mtlo_i,
   input  logic [W-1:0] wr_data_i,
   output logic         rd_valid_o,
   output logic [W-1:0] rd_data_o
);
   generate
      if (W < 4) begin : g_bad_width
         $error("muldiv_unit: W must be at least 4");
      end
   endgenerate

   logic         done;
   logic [W-1:0] res_hi, res_lo;

   md_iter_core #(.W(W)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .op_i     (op_i),
      .a_i      (opa_i),
      .b_i      (opb_i),
      .busy_o   (busy_o),
      .done_o   (done),
      .res_hi_o (res_hi),
      .res_lo_o (res_lo)
   );

   md_hilo #(.W(W)) hilo_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy_o),
      .done_i     (done),
      .res_hi_i   (res_hi),
      .res_lo_i   (res_lo),
      .mthi_i     (mthi_i),
      .mtlo_i     (mtlo_i),
      .wr_data_i  (wr_data_i),
      .mfhi_i     (mfhi_i),
      .mflo_i     (mflo_i),
      .rd_valid_o (rd_valid_o),
      .rd_data_o  (rd_data_o)
   );
endmodule

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
   localparam int W = 32;

   typedef struct packed {
      logic [1:0]   op;
      logic [W-1:0] a;
      logic [W-1:0] b;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 32'hFFFF_FFFD, 32'd7},
      '{2'b00, 32'h8000_0000, 32'h8000_0000},
      '{2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      '{2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      '{2'b01, 32'h1234_5678, 32'h9ABC_DEF0},
      '{2'b11, 32'd100,       32'd7},
      '{2'b11, 32'hFFFF_FFFF, 32'd1},
      '{2'b11, 32'd3,         32'd10},
      '{2'b11, 32'd5,         32'd0},
      '{2'b10, 32'hFFFF_FFF9, 32'd2},
      '{2'b10, 32'd7,         32'hFFFF_FFFE},
      '{2'b10, 32'h8000_0000, 32'hFFFF_FFFF},
      '{2'b10, 32'hFFFF_FFF7, 32'd0},
      '{2'b10, 32'd9,         32'd0}
   };

   logic         clk = 1'b0, rst_n = 1'b0;
   logic         start = 1'b0, mfhi = 1'b0, mflo = 1'b0, mthi = 1'b0, mtlo = 1'b0;
   logic [1:0]   op = 2'b00;
   logic [W-1:0] opa = '0, opb = '0, wdat = '0;
   logic         busy, rd_valid;
   logic [W-1:0] rd_data;
   int           checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   muldiv_unit #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .opa_i(opa), .opb_i(opb),
      .busy_o(busy), .mfhi_i(mfhi), .mflo_i(mflo), .mthi_i(mthi), .mtlo_i(mtlo),
      .wr_data_i(wdat), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] ref_result(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
      longint sa, sb, q, r;
      logic [2*W-1:0] ua, ub;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ua = {32'b0, a};
      ub = {32'b0, b};
      case (o)
         2'b00: return 64'(sa * sb);
         2'b01: return ua * ub;
         2'b11: begin
            if (b == 0) return {a, 32'hFFFF_FFFF};
            return {a % b, a / b};
         end
         default: begin
            if (b == 0) return {a, (a[W-1] ? 32'd1 : 32'hFFFF_FFFF)};
            q = sa / sb;
            r = sa % sb;
            return {r[31:0], q[31:0]};
         end
      endcase
   endfunction

   function automatic string op_tag(input logic [1:0] o, input logic [W-1:0] b);
      if (o == 2'b00) return "R1";
      if (o == 2'b01) return "R2";
      if (b == 0)     return "R5";
      if (o == 2'b11) return "R3";
      return "R4";
   endfunction

   task automatic run_op(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
      int n;
      @(negedge clk);
      start = 1'b1; op = o; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
      chk("R6 busy length", n, W + 1);
   endtask

   task automatic read_reg(input bit hi, output logic [W-1:0] v);
      @(negedge clk);
      mfhi = hi; mflo = !hi;
      @(negedge clk);
      mfhi = 1'b0; mflo = 1'b0;
      chk("R8 rd_valid", {31'b0, rd_valid}, 1);
      v = rd_data;
   endtask

   task automatic move_to(input bit hi, input logic [W-1:0] v);
      @(negedge clk);
      mthi = hi; mtlo = !hi; wdat = v;
      @(negedge clk);
      mthi = 1'b0; mtlo = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0]   v;
      logic [2*W-1:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 busy", {31'b0, busy}, 0);
      chk("R11 rd_valid", {31'b0, rd_valid}, 0);
      read_reg(1'b1, v); chk("R11 HI", v, 0);
      read_reg(1'b0, v); chk("R11 LO", v, 0);

      // table of operations: R1 R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i].op, VECS[i].a, VECS[i].b);
         e = ref_result(VECS[i].op, VECS[i].a, VECS[i].b);
         read_reg(1'b1, v); chk({op_tag(VECS[i].op, VECS[i].b), " HI"}, v, e[2*W-1:W]);
         read_reg(1'b0, v); chk({op_tag(VECS[i].op, VECS[i].b), " LO"}, v, e[W-1:0]);
      end

      // R7: second start while busy is ignored
      @(negedge clk);
      start = 1'b1; op = 2'b01; opa = 32'd3; opb = 32'd5;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1; op = 2'b11; opa = 32'd1000; opb = 32'd9;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      read_reg(1'b0, v); chk("R7 LO", v, 32'd15);
      read_reg(1'b1, v); chk("R7 HI", v, 32'd0);
      chk("R7 no restart", {31'b0, busy}, 0);

      // R10: move-to touches only the selected register
      move_to(1'b1, 32'h1111_1111);
      read_reg(1'b0, v); chk("R10 LO kept", v, 32'd15);
      read_reg(1'b1, v); chk("R10 HI written", v, 32'h1111_1111);
      move_to(1'b0, 32'h2222_2222);
      read_reg(1'b1, v); chk("R10 HI kept", v, 32'h1111_1111);
      read_reg(1'b0, v); chk("R10 LO written", v, 32'h2222_2222);

      // R8: both requests together return HI, single-cycle pulse
      @(negedge clk);
      mfhi = 1'b1; mflo = 1'b1;
      @(negedge clk);
      mfhi = 1'b0; mflo = 1'b0;
      chk("R8 both valid", {31'b0, rd_valid}, 1);
      chk("R8 both HI", rd_data, 32'h1111_1111);
      @(negedge clk);
      chk("R8 pulse ends", {31'b0, rd_valid}, 0);

      // R9: read while busy is held until after busy falls
      @(negedge clk);
      start = 1'b1; op = 2'b01; opa = 32'd6; opb = 32'd7;
      @(negedge clk);
      start = 1'b0;
      mflo = 1'b1;
      @(negedge clk);
      mflo = 1'b0;
      begin
         int early;
         early = 0;
         while (busy) begin
            if (rd_valid) early++;
            @(negedge clk);
         end
         chk("R9 no early valid", early, 0);
      end
      chk("R9 not yet valid", {31'b0, rd_valid}, 0);
      @(negedge clk);
      chk("R9 held valid", {31'b0, rd_valid}, 1);
      chk("R9 held data", rd_data, 32'd42);
      @(negedge clk);
      chk("R9 single pulse", {31'b0, rd_valid}, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule